// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Status Aggregator

This block gathers the interrupt sources of a PCIe root port and combines them into one interrupt line for the host. Event pulses and the four legacy INTx level lines are recorded in two per-source status registers. Each of these has a mask register. A separate bank holds one status bit per MSI vector, a matching mask, the payload of the last message and a pair of message-address registers. MSI arrival reaches the block already decoded, as a vector index and an 8-bit payload presented on a valid/ready pair.

Masking happens at two levels. Any unmasked bit in either source status register sets a core-summary bit in a host status register. Any unmasked MSI vector sets an MSI-pending bit inside source status 0. The host status register has its own mask, and the output `irq_out` is the OR of its unmasked bits. Software reaches every register through a simple 32-bit write/read port. Status bits are cleared by writing 1 to them. Reads are combinational from the current register contents. The MSI port never applies back-pressure: `msi_ready` is 1 at all times, so every cycle with `msi_valid` high is one accepted message.

Top module: `pcie_irq_aggregator`

## Requirements
- R1: After reset all status registers and the payload read 0, every mask register reads all ones on its valid bits (source 0: 0x07FFFFFF, source 1: 0x00000FF0, MSI: 0xFFFFFFFF, host: 0x00FFF0FB), the address registers read 0, and `irq_out` is 0.
- R2: A pulse on `ev0_pulse` bits [15:0], 25 or 26 sets the same bit of source status 0 (offset 0x40) at the next edge. Pulses on bits 16..24 and 27..31 are ignored. Bits [31:27] always read 0.
- R3: A rising edge of `intx_lvl[n]` sets source-0 bit 16+n and source-1 bit 8+n. A falling edge sets source-0 bit 20+n.
- R4: A pulse on `ev1_pulse` bits 4..7 sets the same bit of source status 1 (offset 0x48). Other bits are ignored, and bits [3:0] and [31:12] read 0.
- R5: Writing to a status register (0x40, 0x48, 0x58, 0xA0) clears the bits written as 1. Bits written as 0 keep their value.
- R6: When a set event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R7: A cycle with `msi_valid` high sets MSI status bit `msi_vec` (offset 0x58) and loads `msi_data` into the payload register (0x9C, low 8 bits, upper bits 0).
- R8: Source-0 bit 24 (MSI pending) sets one cycle after any MSI status bit is 1 while its MSI mask bit (0x5C) is 0. It never sets from masked vectors.
- R9: Host status bit 16 (offset 0xA0) sets one cycle after any source-0 or source-1 status bit is 1 while the matching bit in mask 0x44 or 0x4C is 0.
- R10: A pulse on `host_ev` sets the same host status bit for bits in 0x00FFF0FB except bit 16. Other bits are ignored. `irq_out` is 1 exactly when a host status bit is 1 and its host mask bit (0xA4) is 0.
- R11: Mask registers and the MSI address registers (0x50 low, 0x54 high) read back the last written value restricted to their valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev0_pulse | input | 32 | Event pulses for source status 0 |
| ev1_pulse | input | 32 | Event pulses for source status 1 |
| host_ev | input | 32 | Event pulses for host status |
| intx_lvl | input | 4 | Legacy INTx level lines A..D |
| msi_valid | input | 1 | MSI message present |
| msi_ready | output | 1 | Always 1: messages are accepted every cycle |
| msi_vec | input | 5 | MSI vector index |
| msi_data | input | 8 | MSI payload byte |
| irq_out | output | 1 | Summary interrupt |

## Verification
A wrong status bit shows up on a read of its register in the cycle after the triggering edge. It reaches `irq_out` one cycle later through the core-summary bit, or two cycles later for MSI (vector bit, then pending bit, then summary). A clear that is lost, or a clear that beats a simultaneous set, appears as a stale or missing bit on the very next read. A wrong mask reset shows up as `irq_out` rising without any software unmasking. The reference model therefore compares `irq_out` every cycle and compares each register read.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam logic [7:0] OFF_ST0  = 8'h40;
  localparam logic [7:0] OFF_MK0  = 8'h44;
  localparam logic [7:0] OFF_ST1  = 8'h48;
  localparam logic [7:0] OFF_MK1  = 8'h4C;
  localparam logic [7:0] OFF_ALO  = 8'h50;
  localparam logic [7:0] OFF_AHI  = 8'h54;
  localparam logic [7:0] OFF_MST  = 8'h58;
  localparam logic [7:0] OFF_MMK  = 8'h5C;
  localparam logic [7:0] OFF_PAY  = 8'h9C;
  localparam logic [7:0] OFF_HST  = 8'hA0;
  localparam logic [7:0] OFF_HMK  = 8'hA4;

  localparam logic [31:0] VALID0 = 32'h07FF_FFFF;
  localparam logic [31:0] VALID1 = 32'h0000_0FF0;
  localparam logic [31:0] VALIDH = 32'h00FF_F0FB;
  localparam logic [31:0] EV0_OK = VALID0 & ~32'h01FF_0000;
  localparam logic [31:0] EV1_OK = 32'h0000_00F0;
  localparam logic [31:0] EVH_OK = VALIDH & ~32'h0001_0000;

  localparam int ASSERT0_LSB   = 16;
  localparam int DEASSERT0_LSB = 20;
  localparam int MSI_PEND_BIT  = 24;
  localparam int ASSERT1_LSB   = 8;
  localparam int CORE_SUM_BIT  = 16;
endpackage

// File: rtl/pia_w1c_reg.sv
module pia_w1c_reg #(
  parameter int          WIDTH = 32,
  parameter logic [31:0] VALID = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] KEEP = VALID[WIDTH-1:0];

  // set is OR-ed after the clear so a simultaneous set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= ((q_o & ~clr_i) | set_i) & KEEP;
  end
endmodule

// File: rtl/pia_intx_edge.sv
module pia_intx_edge #(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl_i,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  for (genvar n = 0; n < LINES; n++) begin : g_line
    assign rise_o[n] =  lvl_i[n] & ~prev_q[n];
    assign fall_o[n] = ~lvl_i[n] &  prev_q[n];
  end
endmodule

// File: rtl/pia_msi_bank.sv
module pia_msi_bank #(
  parameter int VECS      = 32,
  parameter int PAYLOAD_W = 8,
  parameter int DATA_W    = 32,
  localparam int VEC_W    = $clog2(VECS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msg_valid,
  input  logic [VEC_W-1:0]     msg_vec,
  input  logic [PAYLOAD_W-1:0] msg_data,
  input  logic                 wr_st,
  input  logic                 wr_mk,
  input  logic                 wr_alo,
  input  logic                 wr_ahi,
  input  logic [DATA_W-1:0]    wdata,
  output logic [VECS-1:0]      st_o,
  output logic [VECS-1:0]      mk_o,
  output logic [PAYLOAD_W-1:0] payload_o,
  output logic [DATA_W-1:0]    alo_o,
  output logic [DATA_W-1:0]    ahi_o,
  output logic                 pending_o
);
  logic [VECS-1:0] vec_set;
  logic [VECS-1:0] vec_clr;

  assign vec_set = msg_valid ? (VECS'(1) << msg_vec) : '0;
  assign vec_clr = wr_st ? wdata[VECS-1:0] : '0;

  pia_w1c_reg #(.WIDTH(VECS)) u_vec_st (
    .clk(clk), .rst_n(rst_n), .set_i(vec_set), .clr_i(vec_clr), .q_o(st_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_o      <= '1;
      payload_o <= '0;
      alo_o     <= '0;
      ahi_o     <= '0;
    end else begin
      if (wr_mk)     mk_o      <= wdata[VECS-1:0];
      if (msg_valid) payload_o <= msg_data;
      if (wr_alo)    alo_o     <= wdata;
      if (wr_ahi)    ahi_o     <= wdata;
    end
  end

  assign pending_o = |(st_o & ~mk_o);
endmodule

// File: rtl/pcie_irq_aggregator.sv
module pcie_irq_aggregator
  import pia_pkg::*;
#(
  parameter int NUM_INTX  = 4,
  parameter int MSI_VECS  = 32,
  parameter int PAYLOAD_W = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  localparam int VEC_W    = $clog2(MSI_VECS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wen,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [DATA_W-1:0]    ev0_pulse,
  input  logic [DATA_W-1:0]    ev1_pulse,
  input  logic [DATA_W-1:0]    host_ev,
  input  logic [NUM_INTX-1:0]  intx_lvl,
  input  logic                 msi_valid,
  output logic                 msi_ready,
  input  logic [VEC_W-1:0]     msi_vec,
  input  logic [PAYLOAD_W-1:0] msi_data,
  output logic                 irq_out
);
  logic [NUM_INTX-1:0] intx_rise, intx_fall;
  logic [DATA_W-1:0]   st0_q, st1_q, host_q;
  logic [DATA_W-1:0]   mk0_q, mk1_q, host_mk_q;
  logic [DATA_W-1:0]   set0, set1, seth, clr0, clr1, clrh;
  logic [MSI_VECS-1:0] msi_st_q, msi_mk_q;
  logic [PAYLOAD_W-1:0] msi_pay_q;
  logic [DATA_W-1:0]   msi_alo_q, msi_ahi_q;
  logic                msi_pend, core_sum;
  logic                hit_st0, hit_mk0, hit_st1, hit_mk1, hit_alo, hit_ahi;
  logic                hit_mst, hit_mmk, hit_hst, hit_hmk;

  assign msi_ready = 1'b1;

  assign hit_st0 = bus_wen && (bus_addr == OFF_ST0);
  assign hit_mk0 = bus_wen && (bus_addr == OFF_MK0);
  assign hit_st1 = bus_wen && (bus_addr == OFF_ST1);
  assign hit_mk1 = bus_wen && (bus_addr == OFF_MK1);
  assign hit_alo = bus_wen && (bus_addr == OFF_ALO);
  assign hit_ahi = bus_wen && (bus_addr == OFF_AHI);
  assign hit_mst = bus_wen && (bus_addr == OFF_MST);
  assign hit_mmk = bus_wen && (bus_addr == OFF_MMK);
  assign hit_hst = bus_wen && (bus_addr == OFF_HST);
  assign hit_hmk = bus_wen && (bus_addr == OFF_HMK);

  pia_intx_edge #(.LINES(NUM_INTX)) u_intx (
    .clk(clk), .rst_n(rst_n), .lvl_i(intx_lvl),
    .rise_o(intx_rise), .fall_o(intx_fall)
  );

  pia_msi_bank #(.VECS(MSI_VECS), .PAYLOAD_W(PAYLOAD_W), .DATA_W(DATA_W)) u_msi (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msi_valid), .msg_vec(msi_vec), .msg_data(msi_data),
    .wr_st(hit_mst), .wr_mk(hit_mmk), .wr_alo(hit_alo), .wr_ahi(hit_ahi),
    .wdata(bus_wdata),
    .st_o(msi_st_q), .mk_o(msi_mk_q), .payload_o(msi_pay_q),
    .alo_o(msi_alo_q), .ahi_o(msi_ahi_q), .pending_o(msi_pend)
  );

  // first level: per-source status
  assign set0 = (ev0_pulse & EV0_OK)
              | (DATA_W'(intx_rise) << ASSERT0_LSB)
              | (DATA_W'(intx_fall) << DEASSERT0_LSB)
              | (DATA_W'(msi_pend)  << MSI_PEND_BIT);
  assign set1 = (ev1_pulse & EV1_OK)
              | (DATA_W'(intx_rise) << ASSERT1_LSB);
  assign clr0 = hit_st0 ? bus_wdata : '0;
  assign clr1 = hit_st1 ? bus_wdata : '0;

  pia_w1c_reg #(.WIDTH(DATA_W), .VALID(VALID0)) u_st0 (
    .clk(clk), .rst_n(rst_n), .set_i(set0), .clr_i(clr0), .q_o(st0_q)
  );
  pia_w1c_reg #(.WIDTH(DATA_W), .VALID(VALID1)) u_st1 (
    .clk(clk), .rst_n(rst_n), .set_i(set1), .clr_i(clr1), .q_o(st1_q)
  );

  // second level: host status
  assign core_sum = (|(st0_q & ~mk0_q)) | (|(st1_q & ~mk1_q));
  assign seth = (host_ev & EVH_OK) | (DATA_W'(core_sum) << CORE_SUM_BIT);
  assign clrh = hit_hst ? bus_wdata : '0;

  pia_w1c_reg #(.WIDTH(DATA_W), .VALID(VALIDH)) u_host (
    .clk(clk), .rst_n(rst_n), .set_i(seth), .clr_i(clrh), .q_o(host_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk0_q     <= VALID0;
      mk1_q     <= VALID1;
      host_mk_q <= VALIDH;
    end else begin
      if (hit_mk0) mk0_q     <= bus_wdata & VALID0;
      if (hit_mk1) mk1_q     <= bus_wdata & VALID1;
      if (hit_hmk) host_mk_q <= bus_wdata & VALIDH;
    end
  end

  assign irq_out = |(host_q & ~host_mk_q);

  always_comb begin
    unique case (bus_addr)
      OFF_ST0: bus_rdata = st0_q;
      OFF_MK0: bus_rdata = mk0_q;
      OFF_ST1: bus_rdata = st1_q;
      OFF_MK1: bus_rdata = mk1_q;
      OFF_ALO: bus_rdata = msi_alo_q;
      OFF_AHI: bus_rdata = msi_ahi_q;
      OFF_MST: bus_rdata = DATA_W'(msi_st_q);
      OFF_MMK: bus_rdata = DATA_W'(msi_mk_q);
      OFF_PAY: bus_rdata = DATA_W'(msi_pay_q);
      OFF_HST: bus_rdata = host_q;
      OFF_HMK: bus_rdata = host_mk_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pia_chk.sv
module pia_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic [31:0] ev1_pulse,
  input logic [3:0]  intx_lvl,
  input logic        msi_valid,
  input logic [4:0]  msi_vec,
  input logic        irq_out,
  input logic [31:0] st0,
  input logic [31:0] st1,
  input logic [31:0] msi_st,
  input logic [31:0] host_mk
);
  // R4
  st1_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h48) |-> (bus_rdata[3:0] == 4'h0 && bus_rdata[31:12] == 20'h0));

  // R6
  flush_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev1_pulse[5] |=> st1[5]);

  // R3
  intx_a_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intx_lvl[0]) |=> (st0[16] && st1[8]));

  // R3
  intx_a_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intx_lvl[0]) |=> st0[20]);

  // R7
  msi_vector_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |=> msi_st[$past(msi_vec)]);

  // R10
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mk == 32'h00FF_F0FB) |-> !irq_out);
endmodule

bind pcie_irq_aggregator pia_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .ev1_pulse(ev1_pulse), .intx_lvl(intx_lvl), .msi_valid(msi_valid),
  .msi_vec(msi_vec), .irq_out(irq_out), .st0(st0_q), .st1(st1_q),
  .msi_st(msi_st_q), .host_mk(host_mk_q)
);

// File: tb/pcie_irq_aggregator_tb.sv
module pcie_irq_aggregator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ev0_pulse = '0, ev1_pulse = '0, host_ev = '0;
  logic [3:0]  intx_lvl = '0;
  logic        msi_valid = 1'b0;
  logic        msi_ready;
  logic [4:0]  msi_vec = '0;
  logic [7:0]  msi_data = '0;
  logic        irq_out;

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  pcie_irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev0_pulse(ev0_pulse),
    .ev1_pulse(ev1_pulse), .host_ev(host_ev), .intx_lvl(intx_lvl),
    .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_vec(msi_vec),
    .msi_data(msi_data), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [31:0] m_st0, m_st1, m_host, m_mk0, m_mk1, m_hmk;
  logic [31:0] m_mst, m_mmk, m_alo, m_ahi, m_pay;
  logic [3:0]  m_prev;

  always @(posedge clk) begin
    logic [31:0] w, n0, n1, nh, nm;
    if (!rst_n) begin
      m_st0 = 0; m_st1 = 0; m_host = 0; m_mst = 0; m_pay = 0;
      m_alo = 0; m_ahi = 0; m_prev = 0;
      m_mk0 = 32'h07FF_FFFF; m_mk1 = 32'h0000_0FF0;
      m_hmk = 32'h00FF_F0FB; m_mmk = 32'hFFFF_FFFF;
    end else begin
      n0 = m_st0; n1 = m_st1; nh = m_host; nm = m_mst;
      w = bus_wdata;
      if (bus_wen && bus_addr == 8'h40) n0 = n0 & ~w;
      if (bus_wen && bus_addr == 8'h48) n1 = n1 & ~w;
      if (bus_wen && bus_addr == 8'hA0) nh = nh & ~w;
      if (bus_wen && bus_addr == 8'h58) nm = nm & ~w;
      n0 = n0 | (ev0_pulse & 32'h0600_FFFF);
      n1 = n1 | (ev1_pulse & 32'h0000_00F0);
      nh = nh | (host_ev & 32'h00FE_F0FB);
      for (int i = 0; i < 4; i++) begin
        if (intx_lvl[i] && !m_prev[i]) begin n0[16+i] = 1'b1; n1[8+i] = 1'b1; end
        if (!intx_lvl[i] && m_prev[i]) n0[20+i] = 1'b1;
      end
      if ((m_mst & ~m_mmk) != 0) n0[24] = 1'b1;
      if (((m_st0 & ~m_mk0) != 0) || ((m_st1 & ~m_mk1) != 0)) nh[16] = 1'b1;
      if (msi_valid) begin nm[msi_vec] = 1'b1; m_pay = {24'h0, msi_data}; end
      if (bus_wen && bus_addr == 8'h44) m_mk0 = w & 32'h07FF_FFFF;
      if (bus_wen && bus_addr == 8'h4C) m_mk1 = w & 32'h0000_0FF0;
      if (bus_wen && bus_addr == 8'hA4) m_hmk = w & 32'h00FF_F0FB;
      if (bus_wen && bus_addr == 8'h5C) m_mmk = w;
      if (bus_wen && bus_addr == 8'h50) m_alo = w;
      if (bus_wen && bus_addr == 8'h54) m_ahi = w;
      m_st0 = n0 & 32'h07FF_FFFF;
      m_st1 = n1 & 32'h0000_0FF0;
      m_host = nh & 32'h00FF_F0FB;
      m_mst = nm;
      m_prev = intx_lvl;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h40: return m_st0;  8'h44: return m_mk0;
      8'h48: return m_st1;  8'h4C: return m_mk1;
      8'h50: return m_alo;  8'h54: return m_ahi;
      8'h58: return m_mst;  8'h5C: return m_mmk;
      8'h9C: return m_pay;  8'hA0: return m_host;
      8'hA4: return m_hmk;  default: return 32'h0;
    endcase
  endfunction

  // R10: summary line compared on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_out !== ((m_host & ~m_hmk) != 0)) begin
        errs++;
        $display("FAIL R10 irq_out actual=%b expected=%b", irq_out, ((m_host & ~m_hmk) != 0));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== m_read(a)) begin
      errs++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, m_read(a));
    end
  endtask

  task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errs++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic msi(input logic [4:0] v, input logic [7:0] d);
    @(negedge clk);
    msi_valid = 1'b1; msi_vec = v; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state, literal values
    rd_lit(8'h40, 32'h0, "R1");
    rd_lit(8'h44, 32'h07FF_FFFF, "R1");
    rd_lit(8'h4C, 32'h0000_0FF0, "R1");
    rd_lit(8'h5C, 32'hFFFF_FFFF, "R1");
    rd_lit(8'hA4, 32'h00FF_F0FB, "R1");
    rd_lit(8'h9C, 32'h0, "R1");
    checks++;
    if (msi_ready !== 1'b1) begin errs++; $display("FAIL R7 msi_ready actual=%b expected=1", msi_ready); end

    // R2 generic source-0 events, ignored bits
    @(negedge clk); ev0_pulse = 32'hFFFF_FFFF;
    @(negedge clk); ev0_pulse = '0;
    rd_lit(8'h40, 32'h0600_FFFF, "R2");
    // R5 write-1 clear and write-0 no effect
    wr(8'h40, 32'h0000_0001);
    rd_lit(8'h40, 32'h0600_FFFE, "R5");
    wr(8'h40, 32'h0);
    rd_lit(8'h40, 32'h0600_FFFE, "R5");
    wr(8'h40, 32'hFFFF_FFFF);
    rd_lit(8'h40, 32'h0, "R5");

    // R4 source-1 events
    @(negedge clk); ev1_pulse = 32'hFFFF_FFFF;
    @(negedge clk); ev1_pulse = '0;
    rd_lit(8'h48, 32'h0000_00F0, "R4");
    wr(8'h48, 32'hFFFF_FFFF);

    // R3 INTx edges on lines A and C
    @(negedge clk); intx_lvl = 4'b0101;
    idle(1);
    rd_lit(8'h40, 32'h0005_0000, "R3");
    rd_lit(8'h48, 32'h0000_0500, "R3");
    @(negedge clk); intx_lvl = 4'b0000;
    idle(1);
    rd_lit(8'h40, 32'h0055_0000, "R3");

    // R9 unmask source 0, summary sets; R10 unmask host bit 16
    wr(8'h44, 32'h0);
    idle(1);
    rd(8'hA0, "R9");
    wr(8'hA4, 32'h00FE_F0FB);
    idle(1);
    checks++;
    if (irq_out !== 1'b1) begin errs++; $display("FAIL R10 irq_out actual=%b expected=1", irq_out); end
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'hA0, 32'h0001_0000);
    idle(1);
    rd(8'hA0, "R9");

    // R6 set wins against same-cycle clear
    @(negedge clk);
    ev1_pulse = 32'h0000_0010; bus_wen = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h0000_0010;
    @(negedge clk);
    ev1_pulse = '0; bus_wen = 1'b0; bus_wdata = '0;
    rd_lit(8'h48, 32'h0000_0510, "R6");
    wr(8'h48, 32'hFFFF_FFFF);

    // R8 masked MSI does not set pending; R7 status and payload
    wr(8'h44, 32'h07FF_FFFF);
    msi(5'd5, 8'hA5);
    idle(2);
    rd_lit(8'h58, 32'h0000_0020, "R7");
    rd_lit(8'h9C, 32'h0000_00A5, "R7");
    rd_lit(8'h40, 32'h0, "R8");
    wr(8'h5C, 32'hFFFF_FFDF);
    idle(1);
    rd_lit(8'h40, 32'h0100_0000, "R8");
    msi(5'd31, 8'h3C);
    rd(8'h58, "R7");
    wr(8'h58, 32'h8000_0020);
    rd_lit(8'h58, 32'h0, "R5");

    // R10 host events
    @(negedge clk); host_ev = 32'hFFFF_FFFF;
    @(negedge clk); host_ev = '0;
    rd(8'hA0, "R10");
    wr(8'hA4, 32'hFFFF_FFFF);
    wr(8'hA0, 32'hFFFF_FFFF);

    // R11 read-back
    wr(8'h50, 32'hDEAD_BEEF);
    wr(8'h54, 32'h0000_0012);
    rd_lit(8'h50, 32'hDEAD_BEEF, "R11");
    rd_lit(8'h54, 32'h0000_0012, "R11");
    wr(8'h4C, 32'hFFFF_FFFF);
    rd_lit(8'h4C, 32'h0000_0FF0, "R11");
    rd_lit(8'hA4, 32'h00FF_F0FB, "R11");

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule